// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two component predictors run side by side. The first keeps a short private history for each branch and maps that history to a saturating counter. The second maps a single chip-wide history of recent outcomes to a different counter table. A third table of two-bit chooser counters is indexed by the global history and picks which component's guess becomes the final answer.

The fetch side raises a lookup strobe with a PC. One cycle later the block returns the final direction. It also returns both component guesses and the two history values it used, so the pipeline can carry them along with the branch. When the branch resolves, the pipeline presents the PC, the real outcome and the carried values on the training port. That updates the counters at the indices used at lookup time, the chooser, and both histories. Target prediction, speculative history repair and multiple lookups per cycle are not provided.

Top module: `tournament_predictor`

## Requirements
- R1: After reset every local counter holds 3 and every global counter holds 1 (weakly not-taken). Every per-branch history, the global history and every chooser counter hold 0, and the lookup result is not valid.
- R2: A lookup strobe produces a valid result exactly one cycle later and no valid result otherwise. The result reflects the table contents before any training applied on the same clock edge.
- R3: The per-branch history table has 1024 entries of 10 bits, selected by PC bits [11:2]. Two PCs that agree in those bits share an entry. The selected history is returned with the result.
- R4: The local counter table has 1024 three-bit counters indexed by the branch's history. The local guess is the counter's bit 2 (taken when set).
- R5: The global history is 12 bits. Every training event shifts the outcome in at bit 0 (1 = taken) and drops bit 11. The value current at lookup is returned with the result.
- R6: The global counter table has 4096 two-bit counters indexed by the global history. The global guess is the counter's bit 1.
- R7: A chooser table of 4096 two-bit counters is indexed by the global history. When the chooser's bit 1 is set the final direction is the global guess; otherwise it is the local guess.
- R8: Training increments the local counter at the supplied local history and the global counter at the supplied global history when taken, and decrements them when not taken. The local counters saturate at 0 and 7, the global counters at 0 and 3.
- R9: The chooser at the supplied global history moves only when exactly one supplied guess matched the outcome. It counts up when the global guess was right and down when the local guess was right, saturating at 0 and 3.
- R10: Training shifts the outcome into bit 0 of the history entry selected by the training PC's bits [11:2].
- R11: While the training strobe is low, no table or history changes, whatever the other training inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| predReq | input | 1 | Lookup strobe |
| predPc | input | 32 | PC to look up |
| predValid | output | 1 | Result valid, one cycle after predReq |
| predTaken | output | 1 | Final direction (1 = taken) |
| predLocalTaken | output | 1 | Local component guess |
| predGlobalTaken | output | 1 | Global component guess |
| predGhist | output | 12 | Global history used for the lookup |
| predLhist | output | 10 | Per-branch history used for the lookup |
| trainValid | input | 1 | Training strobe |
| trainPc | input | 32 | PC of the resolved branch |
| trainTaken | input | 1 | Actual outcome (1 = taken) |
| trainLocalTaken | input | 1 | Local guess recorded at lookup |
| trainGlobalTaken | input | 1 | Global guess recorded at lookup |
| trainGhist | input | 12 | Global history recorded at lookup |
| trainLhist | input | 10 | Per-branch history recorded at lookup |

## Verification
The assertions assume that reset is held low for at least one clock before the first lookup or training event. They also assume the single-bit strobes and outcomes are always driven to known values. The chooser checks do not assume the recorded guesses are consistent with the recorded histories. The stimulus drives every input half a cycle away from the active edge and keeps the strobes at 0 or 1 throughout. When the bench feeds back recorded values it takes them from its own model state at lookup time. In a few directed cases it deliberately supplies arbitrary indices to reach specific counters.

// File: rtl/tp_pkg.sv
package tp_pkg;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic capture;     // latch a lookup result this edge
    logic writeEn;     // apply a training event this edge
    logic dirUp;       // outcome of the training event (1 = taken)
    logic chooseUp;    // chooser steps toward the global component
    logic chooseDown;  // chooser steps toward the local component
  } tp_strobe_t;

endpackage

// File: rtl/tp_ctrl.sv
module tp_ctrl
  import tp_pkg::*;
(
  input  logic       predReq,
  input  logic       trainValid,
  input  logic       trainTaken,
  input  logic       trainLocalTaken,
  input  logic       trainGlobalTaken,
  output tp_strobe_t stb
);

  logic localRight;
  logic globalRight;

  assign localRight  = (trainLocalTaken == trainTaken);
  assign globalRight = (trainGlobalTaken == trainTaken);

  always_comb begin
    stb            = '0;
    stb.capture    = predReq;
    stb.writeEn    = trainValid;
    stb.dirUp      = trainTaken;
    stb.chooseUp   = trainValid && globalRight && !localRight;
    stb.chooseDown = trainValid && localRight && !globalRight;
  end

endmodule

// File: rtl/tp_datapath.sv
module tp_datapath
  import tp_pkg::*;
#(
  parameter int LT_IDX_W = 10,
  parameter int LH_W     = 10,
  parameter int LCTR_W   = 3,
  parameter int GH_W     = 12,
  parameter int GCTR_W   = 2,
  parameter int CH_W     = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  tp_strobe_t          stb,
  input  logic [LT_IDX_W-1:0] predIdx,
  input  logic [LT_IDX_W-1:0] trainIdx,
  input  logic [GH_W-1:0]     trainGhist,
  input  logic [LH_W-1:0]     trainLhist,
  output logic                predValid,
  output logic                predTaken,
  output logic                predLocalTaken,
  output logic                predGlobalTaken,
  output logic [GH_W-1:0]     predGhist,
  output logic [LH_W-1:0]     predLhist
);

  localparam int LT_DEPTH = 1 << LT_IDX_W;
  localparam int LC_DEPTH = 1 << LH_W;
  localparam int GH_DEPTH = 1 << GH_W;
  localparam logic [LCTR_W-1:0] LCTR_MAX  = '1;
  localparam logic [GCTR_W-1:0] GCTR_MAX  = '1;
  localparam logic [CH_W-1:0]   CH_MAX    = '1;
  localparam logic [LCTR_W-1:0] LCTR_INIT = LCTR_W'((1 << (LCTR_W - 1)) - 1);
  localparam logic [GCTR_W-1:0] GCTR_INIT = GCTR_W'((1 << (GCTR_W - 1)) - 1);

  logic [LH_W-1:0]   lhistTab [LT_DEPTH];
  logic [LCTR_W-1:0] localCtr [LC_DEPTH];
  logic [GCTR_W-1:0] globalCtr[GH_DEPTH];
  logic [CH_W-1:0]   chooser  [GH_DEPTH];
  logic [GH_W-1:0]   ghist;

  // Lookup path: history -> counter, all from pre-edge state
  logic [LH_W-1:0] lookLhist;
  logic            lookLocal;
  logic            lookGlobal;
  logic            lookPickGlobal;

  assign lookLhist      = lhistTab[predIdx];
  assign lookLocal      = localCtr[lookLhist][LCTR_W-1];
  assign lookGlobal     = globalCtr[ghist][GCTR_W-1];
  assign lookPickGlobal = chooser[ghist][CH_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      predValid       <= 1'b0;
      predTaken       <= 1'b0;
      predLocalTaken  <= 1'b0;
      predGlobalTaken <= 1'b0;
      predGhist       <= '0;
      predLhist       <= '0;
    end else begin
      predValid <= stb.capture;
      if (stb.capture) begin
        predTaken       <= lookPickGlobal ? lookGlobal : lookLocal;
        predLocalTaken  <= lookLocal;
        predGlobalTaken <= lookGlobal;
        predGhist       <= ghist;
        predLhist       <= lookLhist;
      end
    end
  end

  // Global history shift register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ghist <= '0;
    end else if (stb.writeEn) begin
      ghist <= {ghist[GH_W-2:0], stb.dirUp};
    end
  end

  // Per-branch history table
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LT_DEPTH; i++) lhistTab[i] <= '0;
    end else if (stb.writeEn) begin
      lhistTab[trainIdx] <= {lhistTab[trainIdx][LH_W-2:0], stb.dirUp};
    end
  end

  // Local counter table
  logic [LCTR_W-1:0] localOld;
  assign localOld = localCtr[trainLhist];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LC_DEPTH; i++) localCtr[i] <= LCTR_INIT;
    end else if (stb.writeEn) begin
      if (stb.dirUp && localOld != LCTR_MAX)
        localCtr[trainLhist] <= localOld + 1'b1;
      else if (!stb.dirUp && localOld != '0)
        localCtr[trainLhist] <= localOld - 1'b1;
    end
  end

  // Global counter table
  logic [GCTR_W-1:0] globalOld;
  assign globalOld = globalCtr[trainGhist];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < GH_DEPTH; i++) globalCtr[i] <= GCTR_INIT;
    end else if (stb.writeEn) begin
      if (stb.dirUp && globalOld != GCTR_MAX)
        globalCtr[trainGhist] <= globalOld + 1'b1;
      else if (!stb.dirUp && globalOld != '0)
        globalCtr[trainGhist] <= globalOld - 1'b1;
    end
  end

  // Chooser table
  logic [CH_W-1:0] chooseOld;
  assign chooseOld = chooser[trainGhist];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < GH_DEPTH; i++) chooser[i] <= '0;
    end else begin
      if (stb.chooseUp && chooseOld != CH_MAX)
        chooser[trainGhist] <= chooseOld + 1'b1;
      else if (stb.chooseDown && chooseOld != '0)
        chooser[trainGhist] <= chooseOld - 1'b1;
    end
  end

  // R2
  result_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> predValid);
  // R2
  no_spurious_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.capture |=> !predValid);
  // R5
  ghist_newest_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeEn |=> ghist[0] == $past(stb.dirUp));
  // R11
  ghist_idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.writeEn |=> $stable(ghist));
  // R9
  chooser_one_way_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.chooseUp, stb.chooseDown}));
  // R9
  chooser_needs_train_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.chooseUp || stb.chooseDown) |-> stb.writeEn);

endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor
  import tp_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int PC_LSB   = 2,
  parameter int LT_IDX_W = 10,
  parameter int LH_W     = 10,
  parameter int LCTR_W   = 3,
  parameter int GH_W     = 12,
  parameter int GCTR_W   = 2,
  parameter int CH_W     = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            predReq,
  input  logic [PC_W-1:0] predPc,
  output logic            predValid,
  output logic            predTaken,
  output logic            predLocalTaken,
  output logic            predGlobalTaken,
  output logic [GH_W-1:0] predGhist,
  output logic [LH_W-1:0] predLhist,
  input  logic            trainValid,
  input  logic [PC_W-1:0] trainPc,
  input  logic            trainTaken,
  input  logic            trainLocalTaken,
  input  logic            trainGlobalTaken,
  input  logic [GH_W-1:0] trainGhist,
  input  logic [LH_W-1:0] trainLhist
);

  localparam int IDX_HI = PC_LSB + LT_IDX_W;

  tp_strobe_t          stb;
  logic [LT_IDX_W-1:0] predIdx;
  logic [LT_IDX_W-1:0] trainIdx;
  logic                unusedPcBits;

  assign predIdx      = predPc[IDX_HI-1:PC_LSB];
  assign trainIdx     = trainPc[IDX_HI-1:PC_LSB];
  assign unusedPcBits = ^{predPc[PC_W-1:IDX_HI], predPc[PC_LSB-1:0],
                          trainPc[PC_W-1:IDX_HI], trainPc[PC_LSB-1:0]};

  tp_ctrl u_ctrl (
    .predReq          (predReq),
    .trainValid       (trainValid),
    .trainTaken       (trainTaken),
    .trainLocalTaken  (trainLocalTaken),
    .trainGlobalTaken (trainGlobalTaken),
    .stb              (stb)
  );

  tp_datapath #(
    .LT_IDX_W (LT_IDX_W),
    .LH_W     (LH_W),
    .LCTR_W   (LCTR_W),
    .GH_W     (GH_W),
    .GCTR_W   (GCTR_W),
    .CH_W     (CH_W)
  ) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .stb             (stb),
    .predIdx         (predIdx),
    .trainIdx        (trainIdx),
    .trainGhist      (trainGhist),
    .trainLhist      (trainLhist),
    .predValid       (predValid),
    .predTaken       (predTaken),
    .predLocalTaken  (predLocalTaken),
    .predGlobalTaken (predGlobalTaken),
    .predGhist       (predGhist),
    .predLhist       (predLhist)
  );

endmodule

// File: tb/tournament_predictor_test.sv
`timescale 1ns/1ps
module tournament_predictor_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        predReq = 1'b0;
  logic [31:0] predPc = '0;
  logic        predValid, predTaken, predLocalTaken, predGlobalTaken;
  logic [11:0] predGhist;
  logic [9:0]  predLhist;
  logic        trainValid = 1'b0;
  logic [31:0] trainPc = '0;
  logic        trainTaken = 1'b0;
  logic        trainLocalTaken = 1'b0;
  logic        trainGlobalTaken = 1'b0;
  logic [11:0] trainGhist = '0;
  logic [9:0]  trainLhist = '0;

  always #2.5 clk = ~clk;

  tournament_predictor uut (
    .clk(clk), .rstN(rstN),
    .predReq(predReq), .predPc(predPc),
    .predValid(predValid), .predTaken(predTaken),
    .predLocalTaken(predLocalTaken), .predGlobalTaken(predGlobalTaken),
    .predGhist(predGhist), .predLhist(predLhist),
    .trainValid(trainValid), .trainPc(trainPc), .trainTaken(trainTaken),
    .trainLocalTaken(trainLocalTaken), .trainGlobalTaken(trainGlobalTaken),
    .trainGhist(trainGhist), .trainLhist(trainLhist)
  );

  int total = 0;
  int bad = 0;

  // Reference model, built from the requirements
  logic [9:0]  mLht [1024];
  logic [2:0]  mLc  [1024];
  logic [1:0]  mGc  [4096];
  logic [1:0]  mCh  [4096];
  logic [11:0] mGh;

  // Scoreboard: {taken, local, global, ghist, lhist}
  logic [24:0] expQ[$];
  string       tagQ[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 1024; i++) begin mLht[i] = '0; mLc[i] = 3'd3; end
    for (int i = 0; i < 4096; i++) begin mGc[i] = 2'd1; mCh[i] = '0; end
    mGh = '0;
  endtask

  function automatic logic [24:0] modelLook(input logic [31:0] pc);
    logic [9:0] lh;
    logic lp, gp, t;
    lh = mLht[pc[11:2]];
    lp = mLc[lh][2];
    gp = mGc[mGh][1];
    t  = mCh[mGh][1] ? gp : lp;
    return {t, lp, gp, mGh, lh};
  endfunction

  task automatic modelTrain(input logic [31:0] pc, input logic tk, input logic [11:0] gh,
                            input logic [9:0] lh, input logic lp, input logic gp);
    // R8 counters
    if (tk && mLc[lh] != 3'd7) mLc[lh] = mLc[lh] + 3'd1;
    else if (!tk && mLc[lh] != 3'd0) mLc[lh] = mLc[lh] - 3'd1;
    if (tk && mGc[gh] != 2'd3) mGc[gh] = mGc[gh] + 2'd1;
    else if (!tk && mGc[gh] != 2'd0) mGc[gh] = mGc[gh] - 2'd1;
    // R9 chooser
    if ((gp == tk) && (lp != tk) && mCh[gh] != 2'd3) mCh[gh] = mCh[gh] + 2'd1;
    else if ((lp == tk) && (gp != tk) && mCh[gh] != 2'd0) mCh[gh] = mCh[gh] - 2'd1;
    // R10, R5 histories
    mLht[pc[11:2]] = {mLht[pc[11:2]][8:0], tk};
    mGh = {mGh[10:0], tk};
  endtask

  // Drivers: called at a falling edge, consume one cycle
  task automatic doPredict(input logic [31:0] pc, input string tag);
    expQ.push_back(modelLook(pc));
    tagQ.push_back(tag);
    predReq = 1'b1; predPc = pc;
    @(negedge clk);
    predReq = 1'b0;
  endtask

  task automatic driveTrain(input logic v, input logic [31:0] pc, input logic tk, input logic [11:0] gh,
                            input logic [9:0] lh, input logic lp, input logic gp);
    trainValid = v; trainPc = pc; trainTaken = tk; trainGhist = gh;
    trainLhist = lh; trainLocalTaken = lp; trainGlobalTaken = gp;
    if (v) modelTrain(pc, tk, gh, lh, lp, gp);
  endtask

  task automatic doTrainRaw(input logic [31:0] pc, input logic tk, input logic [11:0] gh,
                            input logic [9:0] lh, input logic lp, input logic gp);
    driveTrain(1'b1, pc, tk, gh, lh, lp, gp);
    @(negedge clk);
    trainValid = 1'b0;
  endtask

  task automatic doTrain(input logic [31:0] pc, input logic tk);
    logic [24:0] e;
    e = modelLook(pc);
    doTrainRaw(pc, tk, e[21:10], e[9:0], e[23], e[22]);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rstN && predValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected result", 32'(predValid), 32'd0);
      end else begin
        logic [24:0] act;
        logic [24:0] exp;
        string tg;
        exp = expQ.pop_front();
        tg  = tagQ.pop_front();
        act = {predTaken, predLocalTaken, predGlobalTaken, predGhist, predLhist};
        check(act === exp, tg, 32'(act), 32'(exp));
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: no valid result after reset
    check(predValid == 1'b0, "R1 valid after reset", 32'(predValid), 32'd0);
    doPredict(32'h0000_0000, "R1 reset lookup pc0");
    doPredict(32'h0000_0ffc, "R1 reset lookup top index");
    doPredict(32'h1234_5678, "R1 R2 reset lookup");
    @(negedge clk);

    // R3 R4 R5 R6 R10: repeated taken branch
    for (int k = 0; k < 6; k++) begin
      doPredict(32'h0000_0100, "R3 R4 R5 R6 taken loop");
      doTrain(32'h0000_0100, 1'b1);
    end
    // R3: alias shares history entry
    doPredict(32'h0000_1100, "R3 alias shares entry");
    doPredict(32'h0000_0104, "R3 R10 neighbour untouched");

    // R8: drive local counter at history 0 to saturation and back
    for (int k = 0; k < 9; k++) doTrainRaw(32'h0000_0200, 1'b1, 12'h000, 10'h000, 1'b1, 1'b1);
    doPredict(32'h0000_0300, "R8 local saturated high");
    doTrainRaw(32'h0000_0200, 1'b0, 12'h000, 10'h000, 1'b1, 1'b1);
    doPredict(32'h0000_0300, "R8 local one below max");
    for (int k = 0; k < 9; k++) doTrainRaw(32'h0000_0200, 1'b0, 12'h000, 10'h000, 1'b0, 1'b0);
    doPredict(32'h0000_0300, "R8 local saturated low");
    doTrainRaw(32'h0000_0200, 1'b1, 12'h000, 10'h000, 1'b0, 1'b0);
    doTrainRaw(32'h0000_0200, 1'b1, 12'h000, 10'h000, 1'b0, 1'b0);
    doTrainRaw(32'h0000_0200, 1'b1, 12'h000, 10'h000, 1'b0, 1'b0);
    doPredict(32'h0000_0300, "R8 local recovers from zero");

    // R7 R9: steer chooser toward global at the index the history will hold
    begin
      logic [11:0] tgt;
      tgt = {mGh[8:0], 3'b111};
      for (int k = 0; k < 3; k++) doTrainRaw(32'h0000_0400, 1'b1, tgt, 10'h155, 1'b0, 1'b1);
      doPredict(32'h0000_0300, "R7 R9 chooser picks global");
      // R9: both right -> no chooser move
      doTrainRaw(32'h0000_0400, 1'b1, tgt, 10'h155, 1'b1, 1'b1);
      // R9: local right only -> step down
      doTrainRaw(32'h0000_0400, 1'b0, tgt, 10'h155, 1'b0, 1'b1);
      doPredict(32'h0000_0300, "R9 chooser after mixed updates");
    end

    // R11: training strobe low with busy inputs
    doPredict(32'h0000_0100, "R11 before idle");
    driveTrain(1'b0, 32'h0000_0100, 1'b1, 12'hfff, 10'h3ff, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    doPredict(32'h0000_0100, "R11 after idle strobe");

    // R2: lookup and training on the same edge
    begin
      expQ.push_back(modelLook(32'h0000_0500));
      tagQ.push_back("R2 same-edge lookup sees old state");
      predReq = 1'b1; predPc = 32'h0000_0500;
      driveTrain(1'b1, 32'h0000_0500, 1'b1, mGh, mLht[32'h500 >> 2], 1'b0, 1'b0);
      @(negedge clk);
      predReq = 1'b0; trainValid = 1'b0;
      doPredict(32'h0000_0500, "R2 R5 R10 after same-edge train");
    end

    // Mixed patterns: always taken, alternating, 3-of-4, pseudo-random
    begin
      int seed;
      seed = 7;
      for (int k = 0; k < 240; k++) begin
        logic [31:0] pc;
        logic tk;
        int sel;
        sel = k % 4;
        pc = 32'h0000_0800 + 32'(sel * 4);
        case (sel)
          0: tk = 1'b1;
          1: tk = (k / 4) % 2 == 0;
          2: tk = (k / 4) % 4 != 3;
          default: begin seed = seed * 1103515245 + 12345; tk = seed[16]; end
        endcase
        doPredict(pc, "R4 R6 R7 R8 R9 pattern mix");
        if (k % 5 == 0) doPredict(pc, "R2 back-to-back lookup");
        doTrain(pc, tk);
      end
    end

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R2 results outstanding", 32'(expQ.size()), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule